// File: doc/BRIEF.md
# Layer 2-4 Header Parser

This block walks the headers of a packet presented one byte per cycle and reports which headers it found, where they begin, and the type and protocol values that steered it. It starts on the Ethernet header. Depending on the type field it moves through an optional 802.1Q tag, then an IPv4 or an IPv6 header, then a TCP, UDP or ICMP header. It then enters an accept state that consumes the payload until the end-of-packet marker. Each header state consumes a known number of bytes. On its last byte the state picks its successor from a field of that header.

Bytes arrive on a valid/ready stream with start-of-packet and end-of-packet markers. The parser never stalls, so ready is held high. Results are registered. They stay stable from the cycle parsing ends until the next start-of-packet byte clears them. A one-cycle done pulse marks the end of parsing. If the packet ends while a header is still expected, the error flag is raised together with that pulse.

States: `ST_IDLE` (waiting for a start byte), `ST_ETH`, `ST_VLAN`, `ST_IPV4`, `ST_IPV6`, `ST_TCP`, `ST_UDP`, `ST_ICMP`, `ST_ACCEPT` (payload drain).

Transitions:
- Any state to `ST_ETH`: on a start byte.
- `ST_ETH` to `ST_VLAN`, `ST_IPV4`, `ST_IPV6` or `ST_ACCEPT`: by type.
- `ST_VLAN` to `ST_IPV4`, `ST_IPV6` or `ST_ACCEPT`: by inner type.
- `ST_IPV4` or `ST_IPV6` to `ST_TCP`, `ST_UDP`, `ST_ICMP` or `ST_ACCEPT`: by protocol.
- Transport states to `ST_ACCEPT`: always.
- Any header state or `ST_ACCEPT` to `ST_IDLE`: on the end byte.

Top module: `l24_hdr_parser`

## Requirements
- R1: After reset all result outputs (header flags, offsets, type, protocol, error, done) are zero and in_ready is 1; in_ready stays 1 at all times.
- R2: The first 14 bytes form the Ethernet header; its type is bytes 12 (high) and 13 (low); on completion hdr_vld bit 0 is set and eth_type reports the type.
- R3: Ethernet type 0x8100 selects a 4-byte tag whose bytes 2 (high) and 3 (low) give the inner type, reported in eth_type; on completion hdr_vld bit 1 is set. A further 0x8100 inside the tag is treated as unrecognised.
- R4: Type 0x0800 selects IPv4. Its length is the low nibble of its byte 0 times 4, a nibble below 5 counting as 5. Its protocol is byte 9. On completion hdr_vld bit 2 is set and ip_proto reports the protocol.
- R5: Type 0x86DD selects a 40-byte IPv6 header whose next-header value is byte 6; on completion hdr_vld bit 3 is set and ip_proto reports it.
- R6: Protocol 6 selects a 20-byte TCP header (hdr_vld bit 4), 17 an 8-byte UDP header (bit 5), 1 an 8-byte ICMP header (bit 6); each is followed by accept.
- R7: l3_off is the packet byte index (first byte = 0) at which the IP header starts and l4_off the index at which the transport header starts; each reads 0 when that header was not selected.
- R8: An unrecognised type or protocol goes directly to accept; flags of later headers stay clear, while eth_type or ip_proto still report the value read.
- R9: done is high for exactly one cycle per packet, in the cycle after the byte on which parsing ends (last header byte, or the truncating end byte).
- R10: An end-of-packet byte arriving before the current header is complete, or on the last byte of a header that selected a further header, sets trunc_err together with done and stops parsing.
- R11: Cycles with in_valid low, and valid bytes without start-of-packet while idle, change no output.
- R12: A start-of-packet byte restarts parsing from the Ethernet state and clears every result of the previous packet, even mid-packet.
- R13: Payload bytes after accept leave all results unchanged up to the end-of-packet byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Parser can take a byte (always 1) |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| hdr_vld | output | 7 | Header found: 0 Ethernet, 1 tag, 2 IPv4, 3 IPv6, 4 TCP, 5 UDP, 6 ICMP |
| l3_off | output | OFF_W | Byte index of the IP header |
| l4_off | output | OFF_W | Byte index of the transport header |
| eth_type | output | 16 | Last type field read |
| ip_proto | output | 8 | IP protocol or next-header value |
| trunc_err | output | 1 | Packet ended while a header was expected |
| done | output | 1 | One-cycle pulse at end of parsing |

## Verification
The assertions assume well-formed framing. Every packet begins with a start-of-packet byte, and the markers come only with in_valid high. They also rely on the fact that a first byte can never complete the 14-byte Ethernet header. The bench drives complete frames built from a table of header choices, adding one idle cycle inside some of them. It drives deliberately truncated frames, an abandoned frame followed by a restart, and stray bytes outside any frame. It never raises a marker without in_valid. Expected flags, offsets and done positions are hand-derived from the header lengths in the requirements.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ETH,
        ST_VLAN,
        ST_IPV4,
        ST_IPV6,
        ST_TCP,
        ST_UDP,
        ST_ICMP,
        ST_ACCEPT
    } hp_state_e;

    localparam int FLAG_N   = 7;
    localparam int FL_ETH   = 0;
    localparam int FL_VLAN  = 1;
    localparam int FL_IPV4  = 2;
    localparam int FL_IPV6  = 3;
    localparam int FL_TCP   = 4;
    localparam int FL_UDP   = 5;
    localparam int FL_ICMP  = 6;

    localparam logic [15:0] ET_IPV4 = 16'h0800;
    localparam logic [15:0] ET_VLAN = 16'h8100;
    localparam logic [15:0] ET_IPV6 = 16'h86DD;

    localparam logic [7:0] PR_TCP  = 8'd6;
    localparam logic [7:0] PR_UDP  = 8'd17;
    localparam logic [7:0] PR_ICMP = 8'd1;

    localparam int LEN_ETH  = 14;
    localparam int LEN_VLAN = 4;
    localparam int LEN_IPV6 = 40;
    localparam int LEN_TCP  = 20;
    localparam int LEN_UDP  = 8;
    localparam int LEN_ICMP = 8;
    localparam int IHL_MIN  = 5;

    function automatic int flag_of(hp_state_e s);
        case (s)
            ST_ETH:  return FL_ETH;
            ST_VLAN: return FL_VLAN;
            ST_IPV4: return FL_IPV4;
            ST_IPV6: return FL_IPV6;
            ST_TCP:  return FL_TCP;
            ST_UDP:  return FL_UDP;
            ST_ICMP: return FL_ICMP;
            default: return FL_ETH;
        endcase
    endfunction

endpackage

// File: rtl/hp_hdr_len.sv
module hp_hdr_len
    import hp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  hp_state_e        st,
    input  logic [3:0]       ihl,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        unique case (st)
            ST_ETH:  len = CNT_W'(LEN_ETH);
            ST_VLAN: len = CNT_W'(LEN_VLAN);
            ST_IPV4: len = (ihl < 4'(IHL_MIN)) ? CNT_W'(IHL_MIN * 4)
                                              : CNT_W'({ihl, 2'b00});
            ST_IPV6: len = CNT_W'(LEN_IPV6);
            ST_TCP:  len = CNT_W'(LEN_TCP);
            ST_UDP:  len = CNT_W'(LEN_UDP);
            ST_ICMP: len = CNT_W'(LEN_ICMP);
            default: len = CNT_W'(1);
        endcase
    end
endmodule

// File: rtl/hp_field_grab.sv
module hp_field_grab
    import hp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  hp_state_e        st,
    input  logic [CNT_W-1:0] cnt,
    input  logic [7:0]       data,
    output logic [7:0]       type_hi,
    output logic [7:0]       proto,
    output logic [3:0]       ihl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_hi <= '0;
            proto   <= '0;
            ihl     <= '0;
        end else if (beat) begin
            unique case (st)
                ST_ETH:  if (cnt == CNT_W'(12)) type_hi <= data;
                ST_VLAN: if (cnt == CNT_W'(2))  type_hi <= data;
                ST_IPV4: begin
                    if (cnt == CNT_W'(0)) ihl   <= data[3:0];
                    if (cnt == CNT_W'(9)) proto <= data;
                end
                ST_IPV6: if (cnt == CNT_W'(6)) proto <= data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
    import hp_pkg::*;
#(
    parameter int OFF_W = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       type_hi,
    input  logic [7:0]       proto_in,
    input  logic [CNT_W-1:0] hdr_len,
    output hp_state_e        cur_st,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [FLAG_N-1:0] hdr_vld,
    output logic [OFF_W-1:0] l3_off,
    output logic [OFF_W-1:0] l4_off,
    output logic [15:0]      eth_type,
    output logic [7:0]       ip_proto,
    output logic             trunc_err,
    output logic             done
);
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [OFF_W-1:0] O_ONE = OFF_W'(1);

    hp_state_e        state_q, state_d, succ;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [OFF_W-1:0] pos_q, pos_d, cur_pos;
    logic             start, in_hdr, last;
    logic [15:0]      ftype;

    logic [FLAG_N-1:0] vld_d;
    logic [OFF_W-1:0]  l3_d, l4_d;
    logic [15:0]       type_d;
    logic [7:0]        proto_d;
    logic              trunc_d, done_d;

    // current-beat view: a start byte always begins the Ethernet header
    always_comb begin
        start   = in_valid && in_sop;
        cur_st  = start ? ST_ETH : state_q;
        cur_cnt = start ? '0 : cnt_q;
        cur_pos = start ? '0 : pos_q;
        in_hdr  = cur_st inside {ST_ETH, ST_VLAN, ST_IPV4, ST_IPV6,
                                 ST_TCP, ST_UDP, ST_ICMP};
        last    = in_hdr && (cur_cnt == hdr_len - C_ONE);
        ftype   = {type_hi, in_data};
    end

    // successor chosen from the field of the header being finished
    always_comb begin
        succ = ST_ACCEPT;
        unique case (cur_st)
            ST_ETH: begin
                if (ftype == ET_VLAN)      succ = ST_VLAN;
                else if (ftype == ET_IPV4) succ = ST_IPV4;
                else if (ftype == ET_IPV6) succ = ST_IPV6;
            end
            ST_VLAN: begin
                if (ftype == ET_IPV4)      succ = ST_IPV4;
                else if (ftype == ET_IPV6) succ = ST_IPV6;
            end
            ST_IPV4, ST_IPV6: begin
                if (proto_in == PR_TCP)       succ = ST_TCP;
                else if (proto_in == PR_UDP)  succ = ST_UDP;
                else if (proto_in == PR_ICMP) succ = ST_ICMP;
            end
            default: succ = ST_ACCEPT;
        endcase
    end

    // next state, header byte counter, packet byte position
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pos_d   = pos_q;
        if (in_valid) begin
            if (in_hdr) begin
                pos_d   = cur_pos + O_ONE;
                cnt_d   = last ? '0 : cur_cnt + C_ONE;
                state_d = in_eop ? ST_IDLE : (last ? succ : cur_st);
            end else if (cur_st == ST_ACCEPT && in_eop) begin
                state_d = ST_IDLE;
            end
        end
    end

    // next result values
    always_comb begin
        vld_d   = start ? '0 : hdr_vld;
        l3_d    = start ? '0 : l3_off;
        l4_d    = start ? '0 : l4_off;
        type_d  = start ? '0 : eth_type;
        proto_d = start ? '0 : ip_proto;
        trunc_d = start ? 1'b0 : trunc_err;
        done_d  = 1'b0;
        if (in_valid && in_hdr) begin
            if (last) begin
                vld_d[flag_of(cur_st)] = 1'b1;
                if (cur_st inside {ST_ETH, ST_VLAN}) begin
                    type_d = ftype;
                    if (succ inside {ST_IPV4, ST_IPV6})
                        l3_d = cur_pos + O_ONE;
                end
                if (cur_st inside {ST_IPV4, ST_IPV6}) begin
                    proto_d = proto_in;
                    if (succ inside {ST_TCP, ST_UDP, ST_ICMP})
                        l4_d = cur_pos + O_ONE;
                end
            end
            if (in_eop && (!last || succ != ST_ACCEPT))
                trunc_d = 1'b1;
            if (in_eop || (last && succ == ST_ACCEPT))
                done_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pos_q   <= pos_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_vld   <= '0;
            l3_off    <= '0;
            l4_off    <= '0;
            eth_type  <= '0;
            ip_proto  <= '0;
            trunc_err <= 1'b0;
            done      <= 1'b0;
        end else begin
            hdr_vld   <= vld_d;
            l3_off    <= l3_d;
            l4_off    <= l4_d;
            eth_type  <= type_d;
            ip_proto  <= proto_d;
            trunc_err <= trunc_d;
            done      <= done_d;
        end
    end
endmodule

// File: rtl/l24_hdr_parser.sv
module l24_hdr_parser
    import hp_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic [FLAG_N-1:0] hdr_vld,
    output logic [OFF_W-1:0]  l3_off,
    output logic [OFF_W-1:0]  l4_off,
    output logic [15:0]       eth_type,
    output logic [7:0]        ip_proto,
    output logic              trunc_err,
    output logic              done
);
    localparam int CNT_W = $clog2(15 * 4 + 1);

    hp_state_e        cur_st;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] hdr_len;
    logic [7:0]       type_hi;
    logic [7:0]       proto_q;
    logic [3:0]       ihl_q;

    assign in_ready = 1'b1;

    hp_field_grab #(.CNT_W(CNT_W)) u_grab (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (in_valid),
        .st      (cur_st),
        .cnt     (cur_cnt),
        .data    (in_data),
        .type_hi (type_hi),
        .proto   (proto_q),
        .ihl     (ihl_q)
    );

    hp_hdr_len #(.CNT_W(CNT_W)) u_len (
        .st  (cur_st),
        .ihl (ihl_q),
        .len (hdr_len)
    );

    hp_fsm #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .type_hi   (type_hi),
        .proto_in  (proto_q),
        .hdr_len   (hdr_len),
        .cur_st    (cur_st),
        .cur_cnt   (cur_cnt),
        .hdr_vld   (hdr_vld),
        .l3_off    (l3_off),
        .l4_off    (l4_off),
        .eth_type  (eth_type),
        .ip_proto  (ip_proto),
        .trunc_err (trunc_err),
        .done      (done)
    );
endmodule

// File: rtl/hp_parser_chk.sv
module hp_parser_chk #(
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sop,
    input logic [6:0]       hdr_vld,
    input logic [OFF_W-1:0] l3_off,
    input logic [OFF_W-1:0] l4_off,
    input logic             trunc_err,
    input logic             done
);
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hdr_vld) && $stable(l3_off) && $stable(l4_off) && !done); // R11
    AST_SOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sop |=> hdr_vld == 7'd0 && !trunc_err); // R12
    AST_ETH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|hdr_vld) |-> hdr_vld[0]); // R2
    AST_ONE_NET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hdr_vld[3:2])); // R5
    AST_ONE_XPORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hdr_vld[6:4])); // R6
    AST_XPORT_NEEDS_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (|hdr_vld[6:4]) |-> (|hdr_vld[3:2])); // R6
    AST_XPORT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (|hdr_vld[6:4]) |-> ({1'b0, l4_off} >= {1'b0, l3_off} + (OFF_W+1)'(20))); // R7
    AST_TAG_SHIFTS_NET: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld[1] && (|hdr_vld[3:2]) |-> l3_off == OFF_W'(18)); // R3
    AST_TRUNC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trunc_err) |-> done); // R10
endmodule

bind l24_hdr_parser hp_parser_chk #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .hdr_vld   (hdr_vld),
    .l3_off    (l3_off),
    .l4_off    (l4_off),
    .trunc_err (trunc_err),
    .done      (done)
);

// File: tb/l24_hdr_parser_test.sv
module l24_hdr_parser_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [6:0] hdr_vld;
    logic [7:0] l3_off, l4_off;
    logic [15:0] eth_type;
    logic [7:0] ip_proto;
    logic       trunc_err, done;

    always #2.5 clk = ~clk;

    l24_hdr_parser #(.OFF_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .hdr_vld(hdr_vld), .l3_off(l3_off), .l4_off(l4_off),
        .eth_type(eth_type), .ip_proto(ip_proto),
        .trunc_err(trunc_err), .done(done)
    );

    typedef struct packed {
        logic        tag;
        logic [15:0] et;
        logic [3:0]  ihl;
        logic [7:0]  pr;
        logic [7:0]  pay;
        logic [7:0]  cut;
        logic [6:0]  xv;
        logic [7:0]  xl3;
        logic [7:0]  xl4;
        logic [15:0] xt;
        logic [7:0]  xp;
        logic        xtr;
        logic [7:0]  xd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0800, 4'd5, 8'd6,  8'd6, 8'd0,  7'h15, 8'd14, 8'd34, 16'h0800, 8'd6,  1'b0, 8'd53},
        '{1'b0, 16'h0800, 4'd7, 8'd17, 8'd4, 8'd0,  7'h25, 8'd14, 8'd42, 16'h0800, 8'd17, 1'b0, 8'd49},
        '{1'b1, 16'h0800, 4'd5, 8'd1,  8'd3, 8'd0,  7'h47, 8'd18, 8'd38, 16'h0800, 8'd1,  1'b0, 8'd45},
        '{1'b0, 16'h86DD, 4'd0, 8'd6,  8'd5, 8'd0,  7'h19, 8'd14, 8'd54, 16'h86DD, 8'd6,  1'b0, 8'd73},
        '{1'b1, 16'h86DD, 4'd0, 8'd17, 8'd2, 8'd0,  7'h2B, 8'd18, 8'd58, 16'h86DD, 8'd17, 1'b0, 8'd65},
        '{1'b0, 16'h0806, 4'd5, 8'd6,  8'd4, 8'd0,  7'h01, 8'd0,  8'd0,  16'h0806, 8'd0,  1'b0, 8'd13},
        '{1'b0, 16'h0800, 4'd5, 8'd47, 8'd4, 8'd0,  7'h05, 8'd14, 8'd0,  16'h0800, 8'd47, 1'b0, 8'd33},
        '{1'b0, 16'h0800, 4'd3, 8'd6,  8'd2, 8'd0,  7'h15, 8'd14, 8'd34, 16'h0800, 8'd6,  1'b0, 8'd53},
        '{1'b0, 16'h0800, 4'd5, 8'd6,  8'd4, 8'd20, 7'h01, 8'd14, 8'd0,  16'h0800, 8'd0,  1'b1, 8'd19},
        '{1'b0, 16'h0800, 4'd5, 8'd6,  8'd4, 8'd10, 7'h00, 8'd0,  8'd0,  16'h0000, 8'd0,  1'b1, 8'd9},
        '{1'b1, 16'h88CC, 4'd5, 8'd6,  8'd4, 8'd0,  7'h03, 8'd0,  8'd0,  16'h88CC, 8'd0,  1'b0, 8'd17},
        '{1'b0, 16'h0800, 4'd5, 8'd17, 8'd0, 8'd0,  7'h25, 8'd14, 8'd34, 16'h0800, 8'd17, 1'b0, 8'd41},
        '{1'b0, 16'h0800, 4'd5, 8'd6,  8'd4, 8'd40, 7'h05, 8'd14, 8'd34, 16'h0800, 8'd6,  1'b1, 8'd39},
        '{1'b0, 16'h0800, 4'd5, 8'd6,  8'd0, 8'd14, 7'h01, 8'd14, 8'd0,  16'h0800, 8'd0,  1'b1, 8'd13},
        '{1'b0, 16'h86DD, 4'd0, 8'd58, 8'd3, 8'd0,  7'h09, 8'd14, 8'd0,  16'h86DD, 8'd58, 1'b0, 8'd53}
    };

    logic [7:0] pkt [0:255];
    int pkt_n;
    int checks = 0;
    int errors = 0;
    int done_cnt;
    int done_idx;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build(vec_t v);
        int n = 0;
        int ipl;
        for (int i = 0; i < 12; i++) pkt[n++] = 8'hA0 + 8'(i);
        if (v.tag) begin
            pkt[n++] = 8'h81; pkt[n++] = 8'h00;
            pkt[n++] = 8'h00; pkt[n++] = 8'h05;
        end
        pkt[n++] = v.et[15:8]; pkt[n++] = v.et[7:0];
        ipl = 0;
        if (v.et == 16'h0800) ipl = (v.ihl < 5) ? 20 : int'(v.ihl) * 4;
        if (v.et == 16'h86DD) ipl = 40;
        for (int i = 0; i < ipl; i++) begin
            pkt[n + i] = 8'h11;
            if (v.et == 16'h0800 && i == 0) pkt[n + i] = {4'h4, v.ihl};
            if (v.et == 16'h0800 && i == 9) pkt[n + i] = v.pr;
            if (v.et == 16'h86DD && i == 0) pkt[n + i] = 8'h60;
            if (v.et == 16'h86DD && i == 6) pkt[n + i] = v.pr;
        end
        n += ipl;
        if (ipl != 0) begin
            int tl = (v.pr == 8'd6) ? 20 : (v.pr == 8'd17 || v.pr == 8'd1) ? 8 : 0;
            for (int i = 0; i < tl; i++) pkt[n++] = 8'h33;
        end
        for (int i = 0; i < int'(v.pay); i++) pkt[n++] = 8'h08;
        if (v.cut != 0) n = int'(v.cut);
        pkt_n = n;
    endtask

    task automatic sample_done(int idx);
        @(posedge clk); #1;
        if (done) begin done_cnt++; done_idx = idx; end
    endtask

    task automatic send(int n, bit eop_en, bit gap);
        for (int k = 0; k < n; k++) begin
            if (gap && k == 7) begin
                @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                sample_done(-1);
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = pkt[k];
            in_sop = (k == 0); in_eop = eop_en && (k == n - 1);
            sample_done(k);
        end
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        sample_done(-2);
    endtask

    task automatic check_vec(vec_t v, string tagname);
        chk({"R2 R3 R4 R5 R6 R8 flags ", tagname}, "hdr_vld", 32'(hdr_vld), 32'(v.xv));
        chk({"R7 l3 ", tagname}, "l3_off", 32'(l3_off), 32'(v.xl3));
        chk({"R7 l4 ", tagname}, "l4_off", 32'(l4_off), 32'(v.xl4));
        chk({"R2 R3 R8 type ", tagname}, "eth_type", 32'(eth_type), 32'(v.xt));
        chk({"R4 R5 proto ", tagname}, "ip_proto", 32'(ip_proto), 32'(v.xp));
        chk({"R10 trunc ", tagname}, "trunc_err", 32'(trunc_err), 32'(v.xtr));
        chk({"R9 done count ", tagname}, "done pulses", 32'(done_cnt), 32'd1);
        chk({"R9 R13 done byte ", tagname}, "done index", 32'(done_idx), 32'(v.xd));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "hdr_vld", 32'(hdr_vld), 32'd0);
        chk("R1", "offsets", {16'(l3_off), 16'(l4_off)}, 32'd0);
        chk("R1", "type/proto", {eth_type, 8'd0, ip_proto}, 32'd0);
        chk("R1", "trunc/done", {30'd0, trunc_err, done}, 32'd0);
        chk("R1", "in_ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            done_cnt = 0; done_idx = -3;
            build(VEC[i]);
            send(pkt_n, 1'b1, i[0]);
            check_vec(VEC[i], $sformatf("vec%0d", i));
            chk("R1 ready", "in_ready", 32'(in_ready), 32'd1);
        end

        // R11: stray bytes while idle, no start marker
        done_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); in_valid = 1'b1; in_data = 8'h08; in_sop = 1'b0; in_eop = (k == 5);
            sample_done(k);
        end
        @(negedge clk); in_valid = 1'b0; in_eop = 1'b0;
        sample_done(-2);
        chk("R11 stray", "hdr_vld", 32'(hdr_vld), 32'(VEC[NV-1].xv));
        chk("R11 stray", "ip_proto", 32'(ip_proto), 32'(VEC[NV-1].xp));
        chk("R11 stray", "done pulses", 32'(done_cnt), 32'd0);

        // R12: abandoned packet then restart mid-header
        done_cnt = 0; done_idx = -3;
        build(VEC[3]);
        send(30, 1'b0, 1'b0);
        chk("R12 partial", "hdr_vld", 32'(hdr_vld), 32'h01);
        build(VEC[0]);
        send(pkt_n, 1'b1, 1'b0);
        check_vec(VEC[0], "R12 restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule